// File: doc/BRIEF.md
# PATA PIO Strobe Timing Generator

This block sets the timing of the command strobe for one parallel ATA channel that carries two devices. Each device has a byte-wide timing register that holds an active count and a recovery code. The address-setup time comes from a two-bit setup code. On a channel built with `SHARED_SETUP = 1` one setup code serves both devices. On a channel built with `SHARED_SETUP = 0` each device has its own setup code. All counts are in periods of the bus clock, about 30 ns at 33 MHz.

A controller loads the codes through a one-cycle register-write port. It then raises `req` with `req_dev` set to the target device. The block drives `addr_valid` for the setup time and then raises `strobe` for the active time. It then holds both low for the recovery time and pulses `done` in the last recovery cycle. The counts are not linear binary values: a zero nibble means sixteen clocks, and the setup field goes through a small lookup.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset `busy`, `addr_valid`, `strobe` and `done` are low. Every setup code resets to 2'b11 and every timing register resets to 8'h00, so a transfer with no prior writes runs 5 setup, 16 active and 16 recovery cycles.
- R2: With `busy` low, `req` high at a clock edge starts a transfer for `req_dev`. From the next cycle `busy` and `addr_valid` are high, and `addr_valid` stays high through the setup and active phases.
- R3: A setup write (`cfg_kind` = 0) takes the setup code from `cfg_wdata[7:6]` and decodes it as follows: 2'b01 gives 2 cycles, 2'b10 gives 3, 2'b00 gives 4 and 2'b11 gives 5. Bits 5:0 of that write have no effect.
- R4: A timing write (`cfg_kind` = 1) takes the active count from `cfg_wdata[7:4]`. `strobe` is high, together with `addr_valid`, for that many cycles, or for 16 cycles when the nibble is 0.
- R5: The recovery code is `cfg_wdata[3:0]`. Code 0 gives 16 cycles, code 15 gives 1 cycle, and a code k from 1 to 14 gives k+1 cycles. During recovery `busy` is high and `addr_valid` and `strobe` are low.
- R6: `done` is high for exactly one cycle, the last recovery cycle. `busy` is low in the following cycle.
- R7: A request that arrives while `busy` is high is ignored. If `req` is held high, the next transfer starts only in the cycle after `done`.
- R8: A register write made during a transfer, or in the same cycle as the accepted request, has no effect on that transfer. It applies from the next transfer on.
- R9: With `SHARED_SETUP` = 1 a setup write to either device changes the setup time of both. With `SHARED_SETUP` = 0 it changes only the addressed device.
- R10: Each device has its own timing register. A timing write to one device leaves the other device's transfers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, nominally 33 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one cycle per write |
| cfg_kind | input | 1 | 0 selects the setup code, 1 selects the timing register |
| cfg_dev | input | DEV_W | Device addressed by the write |
| cfg_wdata | input | 8 | Write data |
| req | input | 1 | Transfer request |
| req_dev | input | DEV_W | Device for the requested transfer |
| busy | output | 1 | High from the first setup cycle through the last recovery cycle |
| addr_valid | output | 1 | Address valid during setup and active phases |
| strobe | output | 1 | Command strobe, high during the active phase |
| done | output | 1 | One-cycle pulse in the last recovery cycle |

## Verification
The bench runs the two setup-sharing variants side by side under the same stimulus, each against a queue-based reference. It works through all four setup codes with junk in the low bits and drives both zero nibbles, which a linear decode would turn into a zero-length or one-cycle phase. It also drives recovery code 15, which a plain "code plus one" decode would stretch to 16 cycles. It holds `req` high across whole transfers and writes registers in mid-transfer and in the accept cycle. A design that re-armed early, or that read live register values instead of a snapshot, would shift the strobe edges by cycles. A setup write to device 1 followed by a transfer to device 0 separates the shared variant from the per-device one. A design that mixed the two up would give the wrong setup length on one of them.

// File: rtl/pio_tim_pkg.sv
package pio_tim_pkg;

  // Counters must hold the value 16.
  localparam int CNT_W = 5;

  localparam logic [1:0] SETUP_RST  = 2'b11;
  localparam logic [7:0] ACTREC_RST = 8'h00;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } timing_t;

  // Setup lookup: the field is not a binary count.
  function automatic logic [CNT_W-1:0] setup_cycles(input logic [1:0] code);
    logic [CNT_W-1:0] n;
    unique case (code)
      2'b01:   n = CNT_W'(2);
      2'b10:   n = CNT_W'(3);
      2'b00:   n = CNT_W'(4);
      default: n = CNT_W'(5);
    endcase
    return n;
  endfunction

  // A zero nibble stands for sixteen cycles.
  function automatic logic [CNT_W-1:0] active_cycles(input logic [3:0] nib);
    return (nib == 4'd0) ? CNT_W'(16) : {1'b0, nib};
  endfunction

  // 0 -> 16, 15 -> 1, otherwise code + 1.
  function automatic logic [CNT_W-1:0] recov_cycles(input logic [3:0] code);
    logic [CNT_W-1:0] n;
    if (code == 4'd0)       n = CNT_W'(16);
    else if (code == 4'd15) n = CNT_W'(1);
    else                    n = {1'b0, code} + CNT_W'(1);
    return n;
  endfunction

endpackage

// File: rtl/pio_tim_regs.sv
module pio_tim_regs #(
  parameter int NUM_DEV      = 2,
  parameter bit SHARED_SETUP = 1'b0,
  parameter int DEV_W        = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_kind,
  input  logic [DEV_W-1:0] cfg_dev,
  input  logic [7:0]       cfg_wdata,
  input  logic [DEV_W-1:0] rd_dev,
  output logic [1:0]       rd_setup,
  output logic [7:0]       rd_actrec
);
  import pio_tim_pkg::*;

  logic       setup_wr;
  logic       actrec_wr;
  logic [7:0] actrec_w [NUM_DEV];

  assign setup_wr  = cfg_we && !cfg_kind;
  assign actrec_wr = cfg_we &&  cfg_kind;

  // One active/recovery register per device.
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_actrec
    logic       en;
    logic [7:0] reg_q;
    assign en = actrec_wr && (cfg_dev == DEV_W'(d));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  reg_q <= ACTREC_RST;
      else if (en) reg_q <= cfg_wdata;
    end
    assign actrec_w[d] = reg_q;
  end

  assign rd_actrec = actrec_w[rd_dev];

  // Setup storage: one shared field or one field per device.
  if (SHARED_SETUP) begin : g_setup_shared
    logic [1:0] code_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        code_q <= SETUP_RST;
      else if (setup_wr) code_q <= cfg_wdata[7:6];
    end
    assign rd_setup = code_q;
  end else begin : g_setup_per_dev
    logic [1:0] code_w [NUM_DEV];
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      logic       en;
      logic [1:0] code_q;
      assign en = setup_wr && (cfg_dev == DEV_W'(d));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  code_q <= SETUP_RST;
        else if (en) code_q <= cfg_wdata[7:6];
      end
      assign code_w[d] = code_q;
    end
    assign rd_setup = code_w[rd_dev];
  end

endmodule

// File: rtl/pio_tim_decode.sv
module pio_tim_decode (
  input  logic [1:0]            setup_code,
  input  logic [7:0]            actrec,
  output pio_tim_pkg::timing_t  tim
);
  import pio_tim_pkg::*;

  always_comb begin
    tim.setup  = setup_cycles(setup_code);
    tim.active = active_cycles(actrec[7:4]);
    tim.recov  = recov_cycles(actrec[3:0]);
  end

endmodule

// File: rtl/pio_strobe_seq.sv
module pio_strobe_seq (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  pio_tim_pkg::timing_t tim,
  output logic                 busy,
  output logic                 addr_valid,
  output logic                 strobe,
  output logic                 done
);
  import pio_tim_pkg::*;

  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] act_q, rec_q;
  logic             snap_en;
  logic             last;

  assign last = (cnt_q == CNT_W'(1));

  // Next-state logic: one down-counter reloaded at each phase change.
  always_comb begin
    ph_d    = ph_q;
    cnt_d   = cnt_q;
    snap_en = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (req) begin
          snap_en = 1'b1;
          ph_d    = PH_SETUP;
          cnt_d   = tim.setup;
        end
      end
      PH_SETUP: begin
        if (last) begin
          ph_d  = PH_ACTIVE;
          cnt_d = act_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_ACTIVE: begin
        if (last) begin
          ph_d  = PH_RECOV;
          cnt_d = rec_q;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      PH_RECOV: begin
        if (last) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - CNT_W'(1);
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  // Snapshot taken at accept; later register writes cannot reach it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      rec_q <= '0;
    end else if (snap_en) begin
      act_q <= tim.active;
      rec_q <= tim.recov;
    end
  end

  assign busy       = (ph_q != PH_IDLE);
  assign addr_valid = (ph_q == PH_SETUP) || (ph_q == PH_ACTIVE);
  assign strobe     = (ph_q == PH_ACTIVE);
  assign done       = (ph_q == PH_RECOV) && last;

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer #(
  parameter int NUM_DEV      = 2,
  parameter bit SHARED_SETUP = 1'b0,
  localparam int DEV_W       = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_kind,
  input  logic [DEV_W-1:0] cfg_dev,
  input  logic [7:0]       cfg_wdata,
  input  logic             req,
  input  logic [DEV_W-1:0] req_dev,
  output logic             busy,
  output logic             addr_valid,
  output logic             strobe,
  output logic             done
);
  import pio_tim_pkg::*;

  logic [1:0] sel_setup;
  logic [7:0] sel_actrec;
  timing_t    sel_tim;

  pio_tim_regs #(
    .NUM_DEV      (NUM_DEV),
    .SHARED_SETUP (SHARED_SETUP),
    .DEV_W        (DEV_W)
  ) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind),
    .cfg_dev   (cfg_dev),
    .cfg_wdata (cfg_wdata),
    .rd_dev    (req_dev),
    .rd_setup  (sel_setup),
    .rd_actrec (sel_actrec)
  );

  pio_tim_decode decode_i (
    .setup_code (sel_setup),
    .actrec     (sel_actrec),
    .tim        (sel_tim)
  );

  pio_strobe_seq seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .tim        (sel_tim),
    .busy       (busy),
    .addr_valid (addr_valid),
    .strobe     (strobe),
    .done       (done)
  );

endmodule

// File: rtl/pio_strobe_timer_chk.sv
module pio_strobe_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic busy,
  input logic addr_valid,
  input logic strobe,
  input logic done
);

  // Consecutive strobe cycles seen before the current one.
  logic [5:0] strobe_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      strobe_run_q <= '0;
    else if (strobe) strobe_run_q <= strobe_run_q + 6'd1;
    else             strobe_run_q <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!addr_valid && !strobe && !done));

  assert_start_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(req) && addr_valid && !strobe));

  assert_min_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |-> ($past(addr_valid) && $past(addr_valid, 2)));

  assert_strobe_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> addr_valid);

  assert_strobe_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (strobe_run_q < 6'd16));

  assert_done_in_recov_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && !addr_valid && !strobe));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_ends_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

bind pio_strobe_timer pio_strobe_timer_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req        (req),
  .busy       (busy),
  .addr_valid (addr_valid),
  .strobe     (strobe),
  .done       (done)
);

// File: tb/pio_strobe_timer_tb_top.sv
`timescale 1ns/1ps

// Queue-based reference for one channel variant; compares every cycle.
module pio_strobe_timer_ref #(
  parameter bit SHARED = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       cfg_kind,
  input logic       cfg_dev,
  input logic [7:0] cfg_wdata,
  input logic       req,
  input logic       req_dev,
  input logic       busy,
  input logic       addr_valid,
  input logic       strobe,
  input logic       done
);
  int         n_cmp;
  int         n_bad;
  logic [7:0] q [$];      // {tag[4:0], addr_valid, strobe, done}
  int         setup_code [2];
  int         actrec [2];
  int         since_rst;
  int         s_n, a_n, r_n, code;
  bit         was_idle;
  logic [7:0] exp_e;
  logic       exp_busy;

  initial begin
    n_cmp = 0;
    n_bad = 0;
    since_rst = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      for (int d = 0; d < 2; d++) begin
        setup_code[d] = 3;
        actrec[d]     = 0;
      end
      since_rst = 0;
    end else begin
      was_idle = (q.size() == 0);
      if (!was_idle) void'(q.pop_front());
      // R7: only an idle channel takes a request.
      if (was_idle && req) begin
        // R3 lookup
        case (setup_code[req_dev])
          1: s_n = 2;
          2: s_n = 3;
          0: s_n = 4;
          default: s_n = 5;
        endcase
        // R4: zero nibble is sixteen
        a_n = (actrec[req_dev] >> 4) & 15;
        if (a_n == 0) a_n = 16;
        // R5: 0 -> 16, 15 -> 1, else code+1
        code = actrec[req_dev] & 15;
        if (code == 0)       r_n = 16;
        else if (code == 15) r_n = 1;
        else                 r_n = code + 1;
        for (int i = 0; i < s_n; i++)     q.push_back({5'd3, 3'b100});
        for (int i = 0; i < a_n; i++)     q.push_back({5'd4, 3'b110});
        for (int i = 0; i < r_n - 1; i++) q.push_back({5'd5, 3'b000});
        q.push_back({5'd6, 3'b001});
      end
      // R8: writes land after the accept decision.
      if (cfg_we) begin
        if (!cfg_kind) begin
          if (SHARED) begin           // R9
            setup_code[0] = int'(cfg_wdata[7:6]);
            setup_code[1] = int'(cfg_wdata[7:6]);
          end else begin
            setup_code[cfg_dev] = int'(cfg_wdata[7:6]);
          end
        end else begin
          actrec[cfg_dev] = int'(cfg_wdata);  // R10
        end
      end
      since_rst++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (q.size() != 0) begin
        exp_e    = q[0];
        exp_busy = 1'b1;
      end else begin
        exp_e    = (since_rst < 2) ? {5'd1, 3'b000} : {5'd7, 3'b000};
        exp_busy = 1'b0;
      end
      n_cmp++;
      if ({busy, addr_valid, strobe, done} != {exp_busy, exp_e[2:0]}) begin
        n_bad++;
        $display("FAIL R%0d shared=%0d t=%0t busy/av/stb/done got %b%b%b%b exp %b%b%b%b",
                 exp_e[7:3], SHARED, $time, busy, addr_valid, strobe, done,
                 exp_busy, exp_e[2], exp_e[1], exp_e[0]);
      end
    end
  end

endmodule

module pio_strobe_timer_tb_top;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic       cfg_kind;
  logic [0:0] cfg_dev;
  logic [7:0] cfg_wdata;
  logic       req;
  logic [0:0] req_dev;
  logic       busy_a, av_a, stb_a, done_a;
  logic       busy_b, av_b, stb_b, done_b;
  int         extra_bad;
  bit         finished;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  pio_strobe_timer #(.NUM_DEV(2), .SHARED_SETUP(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_dev(cfg_dev), .cfg_wdata(cfg_wdata), .req(req), .req_dev(req_dev),
    .busy(busy_a), .addr_valid(av_a), .strobe(stb_a), .done(done_a)
  );

  pio_strobe_timer #(.NUM_DEV(2), .SHARED_SETUP(1'b1)) dut_sh_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_dev(cfg_dev), .cfg_wdata(cfg_wdata), .req(req), .req_dev(req_dev),
    .busy(busy_b), .addr_valid(av_b), .strobe(stb_b), .done(done_b)
  );

  pio_strobe_timer_ref #(.SHARED(1'b0)) ref_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_dev(cfg_dev[0]), .cfg_wdata(cfg_wdata), .req(req), .req_dev(req_dev[0]),
    .busy(busy_a), .addr_valid(av_a), .strobe(stb_a), .done(done_a)
  );

  pio_strobe_timer_ref #(.SHARED(1'b1)) ref_sh_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_dev(cfg_dev[0]), .cfg_wdata(cfg_wdata), .req(req), .req_dev(req_dev[0]),
    .busy(busy_b), .addr_valid(av_b), .strobe(stb_b), .done(done_b)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             ref_i.n_cmp + ref_sh_i.n_cmp + 1,
             ref_i.n_bad + ref_sh_i.n_bad + extra_bad);
  endtask

  // All tasks start and end just after a falling edge.
  task automatic wr(input bit kind, input bit dev, input logic [7:0] data);
    cfg_we = 1'b1; cfg_kind = kind; cfg_dev = dev; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_a || busy_b) @(negedge clk);
  endtask

  task automatic xfer(input bit dev);
    req = 1'b1; req_dev = dev;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    @(negedge clk);
  endtask

  initial begin
    extra_bad = 0;
    finished  = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = 1'b0; cfg_dev = '0;
    cfg_wdata = '0; req = 1'b0; req_dev = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    if (busy_a || av_a || stb_a || done_a) begin
      extra_bad++;
      $display("FAIL R1 reset outputs got %b%b%b%b exp 0000", busy_a, av_a, stb_a, done_a);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1, R2: default timing 5/16/16 on device 0
    xfer(1'b0);

    // R3: each setup code, low bits filled with junk
    wr(1'b1, 1'b0, 8'h31);                  // active 3, recovery 2
    wr(1'b0, 1'b0, 8'h7F); xfer(1'b0);      // 01 -> 2
    wr(1'b0, 1'b0, 8'hA5); xfer(1'b0);      // 10 -> 3
    wr(1'b0, 1'b0, 8'h3C); xfer(1'b0);      // 00 -> 4
    wr(1'b0, 1'b0, 8'hC0); xfer(1'b0);      // 11 -> 5

    // R4, R5: nibble corners
    wr(1'b0, 1'b0, 8'h40);
    wr(1'b1, 1'b0, 8'h0F); xfer(1'b0);      // active 16, recovery 1
    wr(1'b1, 1'b0, 8'hF0); xfer(1'b0);      // active 15, recovery 16
    wr(1'b1, 1'b0, 8'h1E); xfer(1'b0);      // active 1, recovery 15
    wr(1'b1, 1'b0, 8'h21); xfer(1'b0);      // active 2, recovery 2

    // R10: device 1 timing differs; device 0 keeps its own
    wr(1'b1, 1'b1, 8'h53);
    xfer(1'b1);
    xfer(1'b0);

    // R9: setup write to device 1 only; shared variant changes device 0 too
    wr(1'b0, 1'b1, 8'h80);
    xfer(1'b0);
    xfer(1'b1);

    // R7: req held high across transfers, back-to-back restarts, then drop
    req = 1'b1; req_dev = 1'b0;
    repeat (25) @(negedge clk);
    req = 1'b0;
    wait_idle();
    @(negedge clk);

    // R8: write in the accept cycle and in mid-transfer
    req = 1'b1; req_dev = 1'b0;
    cfg_we = 1'b1; cfg_kind = 1'b1; cfg_dev = 1'b0; cfg_wdata = 8'h92;
    @(negedge clk);
    req = 1'b0; cfg_we = 1'b0;
    @(negedge clk);
    wr(1'b0, 1'b0, 8'h00);
    wr(1'b1, 1'b0, 8'h44);
    wait_idle();
    @(negedge clk);
    xfer(1'b0);                              // now sees 4 setup, 4/5

    // R6, R7: request while busy on device 1 is ignored
    req = 1'b1; req_dev = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; req_dev = 1'b0;
    @(negedge clk);
    req = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      extra_bad++;
      $display("FAIL R6 watchdog expired got busy exp idle");
      summary();
      $finish;
    end
  end

endmodule